// File: doc/BRIEF.md
# Retry-Weighted Transmit Rate Selector

This block tracks the link quality of one station and chooses the rate index for its next transmissions. Each time a transmit report arrives, the block receives five retry-bucket counts (frames that needed 0, 1, 2, 3 or 4 retries), a drop count, the current signal strength, the mask of rates the station may use and a flag that allows short guard interval. From these it decides whether to move one allowed rate down, one allowed rate up, or stay put.

Two scores are built for each report. Both start from the midpoint of the current rate's low and high thresholds. Each score then adds weighted retry counts and subtracts a weighted total, and the result saturates at zero. The down score takes its weight row from one of two per-rate index tables, chosen by whether the signal is above a per-rate level. The up score takes its row from a third per-rate index table. Failed up attempts are throttled by a waiting counter and a pending counter, which give an escalating back-off. The block also keeps a report-interval level from 0 to 5. Level n stands for an interval of (n+1) × 0x186A timer units. Software or a neighbouring block uses this level to pace the reports.

Top module: `txrate_sel`

## Requirements
- R1: After synchronous reset the rate index is 19 (0x13), short guard interval is off and the interval level is 5. The back-off counters, the reference signal strength and the no-change run counter are all zero.
- R2: A strobe whose report total (five retry counts plus drops) is zero changes no output and no internal state.
- R3: A down step is taken when the down score is below half the high threshold of the effective rate, or when the drop count exceeds that rate's drop limit. The effective rate is the current rate clamped to the highest allowed rate. Weight row column k (k = 0..4) multiplies retry count k, and column 5 multiplies the total.
- R4: If no down step is taken, an up attempt is made when the up score exceeds the effective rate's high threshold.
- R5: A down step works through these cases in priority order: (a) a rate above the highest allowed rate is clamped to it; (b) otherwise a set short-guard flag is cleared and the rate is kept; (c) otherwise the rate moves to the nearest allowed rate below it that is strictly above the lowest allowed rate, and stays unchanged if there is none; (d) a rate at or below the lowest allowed rate becomes the lowest allowed rate.
- R6: An up attempt that is not held moves to the nearest allowed rate above the current one. At the highest allowed rate it instead turns short guard interval on when that is allowed, or forces it off when it is not allowed.
- R7: A signal change of more than 3 from the reference value clears the waiting and pending counters. On a down step, a waiting value of 1 becomes 2 and pending increments, saturating at 4; any other nonzero waiting value clears both counters. On an up attempt, waiting equal to 1 clears both counters. Waiting above 1 holds the rate, stores the signal as the new reference and skips the interval reset. After every up attempt, waiting wraps to 0 when it equals 4 plus the back-off value {2, 10, 24, 40, 60}[pending], and otherwise increments.
- R8: An up attempt that is not held sets the interval level to 0. A down step lowers it by one, with a floor of 0. Every fourth consecutive decision that leaves the rate unchanged raises it by one, with a ceiling of 5.
- R9: Outputs change only on the clock edge that samples a strobe with a nonzero total. Without a strobe they hold their values.
- R10: After a decision the rate index never exceeds the highest allowed rate. With an empty mask, the highest and lowest allowed rates are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rep_valid | input | 1 | One-cycle strobe: a transmit report is present |
| retry_cnt | input | 5*CNT_W | Retry-bucket counts; bucket k in bits [k*CNT_W +: CNT_W] |
| drop_cnt | input | CNT_W | Dropped frames in the report |
| sig_level | input | 8 | Signal strength of the station |
| rate_mask | input | 28 | Bit i set: rate index i may be used |
| sgi_allow | input | 1 | Short guard interval permitted |
| rate_idx | output | 5 | Selected rate index |
| sgi_on | output | 1 | Short guard interval in use |
| rpt_level | output | 3 | Report-interval level, 0 to 5 |

## Verification
Directed reports force heavy drops, clean transfers and zero totals. These separate the drop-limit trigger from the score trigger and show that an empty report is ignored. Masks with a few sparse bits expose the clamp to the highest rate, the search that stops above the lowest rate, and the short-guard toggle at a single-rate mask. A down step that lands between up attempts shows the back-off holding the rate for exactly 13 reports before the next rise. Seeded random reports cover mixed retry profiles, masks, signal jumps and guard permissions. They are compared against a reference model, which exercises both weight-row choices, the pending saturation and the interval ceiling.

// File: rtl/rsel_pkg.sv
// Package: constant tables and shared state type for the rate selector.
// Assumes 28 rate indices; all tables are read-only constants.
package rsel_pkg;
    localparam int NRATE  = 28;
    localparam int RATE_W = 5;
    localparam int LVL_W  = 3;
    localparam int WAIT_W = 7;
    localparam int PEND_W = 3;
    localparam int NROW   = 23;
    localparam logic [RATE_W-1:0] RESET_RATE = 5'd19;
    localparam logic [LVL_W-1:0]  LVL_MAX    = 3'd5;

    // High score threshold per rate; the low threshold is half of it.
    localparam int TH_HI [NRATE] = '{4, 4, 8, 16, 24, 36, 48, 72, 96, 144, 192, 216,
        60, 80, 100, 160, 240, 400, 560, 640, 300, 320, 480, 720, 1000, 1200, 1600, 2000};
    // Signal level above which the strong-signal down row applies.
    localparam int SIG_TH [NRATE] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 36, 38, 42,
        24, 26, 29, 31, 33, 39, 41, 42, 0, 0, 0, 31, 35, 40, 42, 44};
    // Drop count that may be exceeded before a forced down step.
    localparam int DROP_LIM [NRATE] = '{1, 1, 1, 1, 1, 2, 3, 4, 5, 6, 7, 8,
        1, 2, 3, 4, 5, 6, 7, 8, 5, 6, 7, 8, 9, 10, 11, 12};
    // Weight-row selectors: strong-signal down, weak-signal down, up.
    localparam int ROW_STRONG [NRATE] = '{4, 4, 4, 5, 4, 4, 5, 7, 7, 7, 8, 10,
        4, 4, 4, 4, 6, 10, 11, 13, 5, 5, 7, 7, 8, 11, 13, 15};
    localparam int ROW_WEAK [NRATE] = '{10, 10, 11, 12, 10, 10, 11, 12, 13, 16, 19, 20,
        11, 12, 13, 14, 15, 17, 19, 21, 9, 9, 9, 9, 12, 14, 17, 19};
    localparam int ROW_UP [NRATE] = '{12, 13, 13, 15, 13, 14, 15, 15, 16, 18, 19, 20,
        15, 16, 16, 18, 18, 19, 20, 21, 17, 17, 18, 19, 19, 19, 20, 21};
    // Weight rows {w0, w1, w2, w3, w4, w_total}, 6 bits each, w0 in the top bits.
    localparam logic [35:0] WROW [NROW] = '{
        {6'd5,  6'd4,  6'd3,  6'd2,  6'd0, 6'd3},
        {6'd6,  6'd5,  6'd4,  6'd3,  6'd0, 6'd4},
        {6'd6,  6'd5,  6'd4,  6'd2,  6'd0, 6'd4},
        {6'd8,  6'd7,  6'd6,  6'd4,  6'd0, 6'd6},
        {6'd10, 6'd9,  6'd8,  6'd6,  6'd0, 6'd8},
        {6'd10, 6'd9,  6'd8,  6'd4,  6'd0, 6'd8},
        {6'd10, 6'd9,  6'd8,  6'd2,  6'd0, 6'd8},
        {6'd10, 6'd9,  6'd8,  6'd0,  6'd0, 6'd8},
        {6'd18, 6'd17, 6'd16, 6'd8,  6'd0, 6'd16},
        {6'd26, 6'd25, 6'd24, 6'd16, 6'd0, 6'd24},
        {6'd34, 6'd33, 6'd32, 6'd24, 6'd0, 6'd32},
        {6'd34, 6'd31, 6'd28, 6'd20, 6'd0, 6'd32},
        {6'd34, 6'd31, 6'd27, 6'd18, 6'd0, 6'd32},
        {6'd34, 6'd31, 6'd26, 6'd16, 6'd0, 6'd32},
        {6'd34, 6'd30, 6'd22, 6'd16, 6'd0, 6'd32},
        {6'd34, 6'd30, 6'd24, 6'd16, 6'd0, 6'd32},
        {6'd49, 6'd46, 6'd40, 6'd16, 6'd0, 6'd48},
        {6'd49, 6'd45, 6'd32, 6'd0,  6'd0, 6'd48},
        {6'd49, 6'd45, 6'd22, 6'd18, 6'd0, 6'd48},
        {6'd49, 6'd40, 6'd24, 6'd16, 6'd0, 6'd48},
        {6'd49, 6'd32, 6'd18, 6'd12, 6'd0, 6'd48},
        {6'd49, 6'd22, 6'd18, 6'd14, 6'd0, 6'd48},
        {6'd49, 6'd16, 6'd16, 6'd0,  6'd0, 6'd48}};
    // Extra waiting reports per pending level.
    localparam int BACKOFF [5] = '{2, 10, 24, 40, 60};

    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic              sgi;
        logic [WAIT_W-1:0] wait_cnt;
        logic [PEND_W-1:0] pend;
        logic [7:0]        ref_sig;
        logic [LVL_W-1:0]  lvl;
        logic [2:0]        stable;
    } sel_state_t;

    // Score start value: midpoint of a rate's low and high thresholds.
    function automatic logic [11:0] mid_score(input logic [RATE_W-1:0] r);
        return 12'((TH_HI[r] + (TH_HI[r] >> 1)) >> 1);
    endfunction
endpackage

// File: rtl/rsel_bounds.sv
// Highest and lowest allowed rate from the rate mask.
// Assumes an empty mask yields 0 for both.
module rsel_bounds
    import rsel_pkg::*;
(
    input  logic [NRATE-1:0]  mask,
    output logic [RATE_W-1:0] top_rate,
    output logic [RATE_W-1:0] bot_rate
);
    // Priority-encode the highest and the lowest set bit.
    always_comb begin
        top_rate = '0;
        bot_rate = '0;
        for (int i = 0; i < NRATE; i++)
            if (mask[i]) top_rate = RATE_W'(i);
        for (int i = NRATE - 1; i >= 0; i--)
            if (mask[i]) bot_rate = RATE_W'(i);
    end
endmodule

// File: rtl/rsel_search.sv
// Neighbour search in the rate mask: the next allowed rate above cur,
// and the next allowed rate below cur that is strictly above floor_rate.
module rsel_search
    import rsel_pkg::*;
(
    input  logic [NRATE-1:0]  mask,
    input  logic [RATE_W-1:0] cur,
    input  logic [RATE_W-1:0] floor_rate,
    output logic              up_hit,
    output logic [RATE_W-1:0] up_rate,
    output logic              dn_hit,
    output logic [RATE_W-1:0] dn_rate
);
    // Scan toward cur from both ends; the last hit is the nearest one.
    always_comb begin
        up_hit  = 1'b0;
        up_rate = '0;
        dn_hit  = 1'b0;
        dn_rate = '0;
        for (int i = NRATE - 1; i >= 0; i--)
            if (mask[i] && (i > int'(cur))) begin
                up_hit  = 1'b1;
                up_rate = RATE_W'(i);
            end
        for (int i = 0; i < NRATE; i++)
            if (mask[i] && (i < int'(cur)) && (i > int'(floor_rate))) begin
                dn_hit  = 1'b1;
                dn_rate = RATE_W'(i);
            end
    end
endmodule

// File: rtl/rsel_score.sv
// Retry-penalty score: base plus weighted retry buckets minus weighted total,
// saturating at zero. Assumes SC_W holds the largest sum without overflow.
module rsel_score #(
    parameter int CNT_W = 8,
    parameter int SC_W  = CNT_W + 10
) (
    input  logic [5*CNT_W-1:0] tries,
    input  logic [CNT_W+2:0]   total,
    input  logic [11:0]        base,
    input  logic [35:0]        wrow,
    output logic [SC_W-1:0]    score
);
    logic [SC_W-1:0] acc;
    logic [SC_W-1:0] pen;

    // Accumulate the weighted buckets and saturate the subtraction.
    always_comb begin
        acc = SC_W'(base);
        for (int k = 0; k < 5; k++)
            acc = acc + SC_W'(tries[k*CNT_W +: CNT_W]) * SC_W'(wrow[35-6*k -: 6]);
        pen   = SC_W'(total) * SC_W'(wrow[5:0]);
        score = (acc > pen) ? (acc - pen) : '0;
    end
endmodule

// File: rtl/txrate_sel.sv
// Top: per-report rate decision for one station. Holds rate, short-guard flag,
// back-off counters, reference signal, interval level and the no-change run.
// Assumes rep_valid is a single-cycle strobe; outputs update on the next edge.
module txrate_sel
    import rsel_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rep_valid,
    input  logic [5*CNT_W-1:0] retry_cnt,
    input  logic [CNT_W-1:0]   drop_cnt,
    input  logic [7:0]         sig_level,
    input  logic [NRATE-1:0]   rate_mask,
    input  logic               sgi_allow,
    output logic [RATE_W-1:0]  rate_idx,
    output logic               sgi_on,
    output logic [LVL_W-1:0]   rpt_level
);
    localparam int TOT_W = CNT_W + 3;
    localparam int SC_W  = CNT_W + 10;

    sel_state_t        cur, nx;
    logic [TOT_W-1:0]  total;
    logic [RATE_W-1:0] top_rate, bot_rate, eff_rate;
    logic              up_hit, dn_hit, sig_jump, go_down, go_up, hold_up;
    logic [RATE_W-1:0] up_rate, dn_rate;
    logic [4:0]        row_dn, row_up;
    logic [11:0]       base;
    logic [SC_W-1:0]   dn_score, up_score;

    rsel_bounds u_bounds (.mask(rate_mask), .top_rate(top_rate), .bot_rate(bot_rate));

    rsel_search u_search (
        .mask(rate_mask), .cur(cur.rate), .floor_rate(bot_rate),
        .up_hit(up_hit), .up_rate(up_rate), .dn_hit(dn_hit), .dn_rate(dn_rate)
    );

    // Report total, effective rate, row choice and signal jump detection.
    always_comb begin
        total = TOT_W'(drop_cnt);
        for (int k = 0; k < 5; k++)
            total = total + TOT_W'(retry_cnt[k*CNT_W +: CNT_W]);
        eff_rate = (cur.rate > top_rate) ? top_rate : cur.rate;
        row_dn   = (int'(sig_level) > SIG_TH[eff_rate]) ? 5'(ROW_STRONG[eff_rate])
                                                        : 5'(ROW_WEAK[eff_rate]);
        row_up   = 5'(ROW_UP[eff_rate]);
        base     = mid_score(cur.rate);
        sig_jump = ({1'b0, sig_level} > ({1'b0, cur.ref_sig} + 9'd3)) ||
                   ({1'b0, cur.ref_sig} > ({1'b0, sig_level} + 9'd3));
    end

    rsel_score #(.CNT_W(CNT_W), .SC_W(SC_W)) u_dn_score (
        .tries(retry_cnt), .total(total), .base(base), .wrow(WROW[row_dn]), .score(dn_score)
    );
    rsel_score #(.CNT_W(CNT_W), .SC_W(SC_W)) u_up_score (
        .tries(retry_cnt), .total(total), .base(base), .wrow(WROW[row_up]), .score(up_score)
    );

    // Threshold comparisons; a down step wins over an up attempt.
    always_comb begin
        go_down = (int'(dn_score) < (TH_HI[eff_rate] >> 1)) ||
                  (int'(drop_cnt) > DROP_LIM[eff_rate]);
        go_up   = !go_down && (int'(up_score) > TH_HI[eff_rate]);
    end

    // Next-state decision for one report.
    always_comb begin
        nx      = cur;
        hold_up = 1'b0;
        if (rep_valid && (total != '0)) begin
            if (sig_jump) begin
                nx.wait_cnt = '0;
                nx.pend     = '0;
            end
            if (go_down) begin
                if (cur.rate > top_rate)      nx.rate = top_rate;
                else if (cur.sgi)             nx.sgi  = 1'b0;
                else if (cur.rate > bot_rate) begin
                    if (dn_hit) nx.rate = dn_rate;
                end
                else                          nx.rate = bot_rate;
                if (nx.wait_cnt == WAIT_W'(1)) begin
                    nx.wait_cnt = WAIT_W'(2);
                    nx.pend     = nx.pend + PEND_W'(1);
                end else if (nx.wait_cnt != '0) begin
                    nx.wait_cnt = '0;
                    nx.pend     = '0;
                end
                if (nx.pend > PEND_W'(4)) nx.pend = PEND_W'(4);
                if (nx.lvl != '0) nx.lvl = nx.lvl - LVL_W'(1);
            end else if (go_up) begin
                if (nx.wait_cnt == WAIT_W'(1)) begin
                    nx.wait_cnt = '0;
                    nx.pend     = '0;
                end else if (nx.wait_cnt > WAIT_W'(1)) begin
                    nx.ref_sig = sig_level;
                    hold_up    = 1'b1;
                end
                if (!hold_up) begin
                    nx.lvl = '0;
                    if (cur.rate < top_rate) begin
                        if (up_hit) nx.rate = up_rate;
                    end else if (cur.rate == top_rate) begin
                        if (sgi_allow && !cur.sgi) nx.sgi = 1'b1;
                        else if (!sgi_allow)       nx.sgi = 1'b0;
                    end else begin
                        nx.rate = top_rate;
                    end
                end
                if (int'(nx.wait_cnt) == 4 + BACKOFF[nx.pend]) nx.wait_cnt = '0;
                else                                          nx.wait_cnt = nx.wait_cnt + WAIT_W'(1);
            end
            if (nx.rate > top_rate) nx.rate = top_rate;
            if (nx.rate == cur.rate) begin
                if (cur.stable == 3'd3) begin
                    nx.stable = '0;
                    if (nx.lvl != LVL_MAX) nx.lvl = nx.lvl + LVL_W'(1);
                end else begin
                    nx.stable = cur.stable + 3'd1;
                end
            end else begin
                nx.stable = '0;
            end
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur.rate     <= RESET_RATE;
            cur.sgi      <= 1'b0;
            cur.wait_cnt <= '0;
            cur.pend     <= '0;
            cur.ref_sig  <= '0;
            cur.lvl      <= LVL_MAX;
            cur.stable   <= '0;
        end else begin
            cur <= nx;
        end
    end

    assign rate_idx  = cur.rate;
    assign sgi_on    = cur.sgi;
    assign rpt_level = cur.lvl;
endmodule

// File: rtl/txrate_sel_chk.sv
// Checker bound to txrate_sel: port-level properties of the rate selector.
module txrate_sel_chk
    import rsel_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rep_valid,
    input logic [5*CNT_W-1:0] retry_cnt,
    input logic [CNT_W-1:0]   drop_cnt,
    input logic [NRATE-1:0]   rate_mask,
    input logic               sgi_allow,
    input logic [RATE_W-1:0]  rate_idx,
    input logic               sgi_on,
    input logic [LVL_W-1:0]   rpt_level
);
    logic [CNT_W+2:0] rep_sum;

    // Independent report total for the checks below.
    always_comb begin
        rep_sum = (CNT_W+3)'(drop_cnt);
        for (int k = 0; k < 5; k++)
            rep_sum = rep_sum + (CNT_W+3)'(retry_cnt[k*CNT_W +: CNT_W]);
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rep_valid |=> $stable(rate_idx) && $stable(sgi_on) && $stable(rpt_level)); // R9
    AST_EMPTY_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_valid && rep_sum == '0) |=> $stable(rate_idx) && $stable(sgi_on) && $stable(rpt_level)); // R2
    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_level <= LVL_MAX); // R8
    AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rep_valid |=> (rpt_level == '0) ||
            ((4'(rpt_level) + 4'd1 >= 4'($past(rpt_level))) && (4'(rpt_level) <= 4'($past(rpt_level)) + 4'd1))); // R8
    AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_valid && rep_sum != '0 && rate_mask == '0) |=> rate_idx == '0); // R10
    AST_SGI_NEEDS_ALLOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sgi_on) |-> $past(sgi_allow)); // R6
endmodule

bind txrate_sel txrate_sel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rep_valid(rep_valid), .retry_cnt(retry_cnt),
    .drop_cnt(drop_cnt), .rate_mask(rate_mask), .sgi_allow(sgi_allow),
    .rate_idx(rate_idx), .sgi_on(sgi_on), .rpt_level(rpt_level)
);

// File: tb/txrate_sel_bench.sv
`timescale 1ns/1ps
module txrate_sel_bench;
    import rsel_pkg::*;
    localparam int CNT_W = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               rep_valid = 1'b0;
    logic [5*CNT_W-1:0] retry_cnt = '0;
    logic [CNT_W-1:0]   drop_cnt = '0;
    logic [7:0]         sig_level = '0;
    logic [NRATE-1:0]   rate_mask = '1;
    logic               sgi_allow = 1'b0;
    logic [RATE_W-1:0]  rate_idx;
    logic               sgi_on;
    logic [LVL_W-1:0]   rpt_level;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int m_rate, m_sgi, m_wait, m_pend, m_ref, m_lvl, m_stab;

    always #2 clk = ~clk;

    txrate_sel #(.CNT_W(CNT_W)) u_txrate_sel (
        .clk(clk), .rst_n(rst_n), .rep_valid(rep_valid), .retry_cnt(retry_cnt),
        .drop_cnt(drop_cnt), .sig_level(sig_level), .rate_mask(rate_mask),
        .sgi_allow(sgi_allow), .rate_idx(rate_idx), .sgi_on(sgi_on), .rpt_level(rpt_level)
    );

    task automatic check(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic int wt(input int row, input int k);
        return int'(WROW[row][35-6*k -: 6]);
    endfunction

    function automatic int score(input int base, input int row, input int c[5], input int tot);
        int acc = base;
        for (int k = 0; k < 5; k++) acc += c[k] * wt(row, k);
        return (acc > tot * wt(row, 5)) ? acc - tot * wt(row, 5) : 0;
    endfunction

    // Reference model of one report, written from the requirements.
    task automatic model(input int c[5], input int drop, input int sig,
                         input logic [NRATE-1:0] mask, input int allow);
        int tot, hi, lo, r, rd, ru, dn, up, nr, held;
        bit down, upg, found;
        tot = drop;
        for (int k = 0; k < 5; k++) tot += c[k];
        if (tot == 0) return;
        hi = 0; lo = 0;
        for (int i = 0; i < NRATE; i++) if (mask[i]) hi = i;
        for (int i = NRATE - 1; i >= 0; i--) if (mask[i]) lo = i;
        if (sig > m_ref + 3 || m_ref > sig + 3) begin m_wait = 0; m_pend = 0; end
        r  = (m_rate > hi) ? hi : m_rate;
        rd = (sig > SIG_TH[r]) ? ROW_STRONG[r] : ROW_WEAK[r];
        ru = ROW_UP[r];
        dn = score((TH_HI[m_rate] + TH_HI[m_rate] / 2) / 2, rd, c, tot);
        up = score((TH_HI[m_rate] + TH_HI[m_rate] / 2) / 2, ru, c, tot);
        down = (dn < TH_HI[r] / 2) || (drop > DROP_LIM[r]);
        upg  = !down && (up > TH_HI[r]);
        nr = m_rate;
        if (down) begin
            if (m_rate > hi) nr = hi;
            else if (m_sgi != 0) m_sgi = 0;
            else if (m_rate > lo) begin
                found = 0;
                for (int i = m_rate - 1; i > lo; i--)
                    if (!found && mask[i]) begin nr = i; found = 1; end
            end else nr = lo;
            if (m_wait == 1) begin m_wait = 2; m_pend++; end
            else if (m_wait != 0) begin m_wait = 0; m_pend = 0; end
            if (m_pend > 4) m_pend = 4;
            if (m_lvl > 0) m_lvl--;
        end else if (upg) begin
            held = 0;
            if (m_wait == 1) begin m_wait = 0; m_pend = 0; end
            else if (m_wait > 1) begin m_ref = sig; held = 1; end
            if (held == 0) begin
                m_lvl = 0;
                if (m_rate < hi) begin
                    found = 0;
                    for (int i = m_rate + 1; i <= hi; i++)
                        if (!found && mask[i]) begin nr = i; found = 1; end
                end else if (m_rate == hi) begin
                    if (allow != 0 && m_sgi == 0) m_sgi = 1;
                    else if (allow == 0) m_sgi = 0;
                end else nr = hi;
            end
            if (m_wait == 4 + BACKOFF[m_pend]) m_wait = 0; else m_wait++;
        end
        if (nr > hi) nr = hi;
        if (nr == m_rate) begin
            if (m_stab == 3) begin m_stab = 0; if (m_lvl < 5) m_lvl++; end
            else m_stab++;
        end else m_stab = 0;
        m_rate = nr;
    endtask

    // Drive one report, advance the model, then compare after the register edge.
    task automatic send(input string req, input int c0, input int c1, input int c2,
                        input int c3, input int c4, input int drop, input int sig);
        int c[5];
        c = '{c0, c1, c2, c3, c4};
        @(negedge clk);
        for (int k = 0; k < 5; k++) retry_cnt[k*CNT_W +: CNT_W] = CNT_W'(c[k]);
        drop_cnt  = CNT_W'(drop);
        sig_level = 8'(sig);
        rep_valid = 1'b1;
        model(c, drop, sig, rate_mask, int'(sgi_allow));
        @(negedge clk);
        rep_valid = 1'b0;
        check(req, "rate", int'(rate_idx), m_rate);
        check(req, "sgi", int'(sgi_on), m_sgi);
        check(req, "level", int'(rpt_level), m_lvl);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        int r0, rd, rs;
        seed = $urandom(32'h5A17);
        m_rate = 19; m_sgi = 0; m_wait = 0; m_pend = 0; m_ref = 0; m_lvl = 5; m_stab = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset rate", int'(rate_idx), 19);
        check("R1", "reset sgi", int'(sgi_on), 0);
        check("R1", "reset level", int'(rpt_level), 5);

        send("R2", 0, 0, 0, 0, 0, 0, 50);
        check("R2", "empty report rate", int'(rate_idx), 19);
        check("R2", "empty report level", int'(rpt_level), 5);

        send("R3", 0, 0, 0, 0, 0, 20, 50);
        check("R3", "drop-forced down rate", int'(rate_idx), 18);
        check("R8", "down lowers level", int'(rpt_level), 4);

        send("R4", 200, 0, 0, 0, 0, 0, 50);
        check("R4", "clean report up rate", int'(rate_idx), 19);
        check("R8", "up attempt resets level", int'(rpt_level), 0);

        // Down right after an up arms the back-off; 13 held up attempts follow.
        send("R7", 0, 0, 0, 0, 0, 20, 2);
        check("R7", "down after up", int'(rate_idx), 18);
        for (int n = 0; n < 13; n++) send("R7", 200, 0, 0, 0, 0, 0, 2);
        check("R7", "rate held by back-off", int'(rate_idx), 18);
        check("R8", "level after 12 unchanged", int'(rpt_level), 3);
        send("R7", 200, 0, 0, 0, 0, 0, 2);
        check("R7", "rise after back-off wraps", int'(rate_idx), 19);

        // Sparse mask {2,5,9}: clamp, search, stop above the lowest rate.
        rate_mask = 28'h0000224;
        send("R5", 0, 0, 0, 0, 0, 20, 2);
        check("R10", "clamp to highest allowed", int'(rate_idx), 9);
        send("R5", 0, 0, 0, 0, 0, 20, 2);
        check("R5", "step to next allowed below", int'(rate_idx), 5);
        send("R5", 0, 0, 0, 0, 0, 20, 2);
        check("R5", "no rate above lowest, unchanged", int'(rate_idx), 5);

        // Single-rate mask: short guard toggles at the top rate.
        rate_mask = 28'h0000020;
        sgi_allow = 1'b1;
        send("R6", 20, 0, 0, 0, 0, 0, 2);
        check("R6", "sgi set at top rate", int'(sgi_on), 1);
        send("R5", 0, 0, 0, 0, 0, 20, 2);
        check("R5", "down clears sgi first", int'(sgi_on), 0);
        check("R5", "rate kept when clearing sgi", int'(rate_idx), 5);

        // Idle cycles with changing inputs leave outputs alone.
        @(negedge clk);
        drop_cnt = 8'd50; sig_level = 8'd90; rate_mask = 28'h0000001;
        @(negedge clk);
        check("R9", "idle rate hold", int'(rate_idx), m_rate);
        check("R9", "idle level hold", int'(rpt_level), m_lvl);

        // Empty mask collapses the rate to 0.
        rate_mask = '0;
        send("R10", 3, 0, 0, 0, 0, 0, 2);
        check("R10", "empty mask rate", int'(rate_idx), 0);

        // Seeded random mix checked against the model.
        for (int n = 0; n < 600; n++) begin
            if (n % 40 == 0) begin
                rate_mask = ($urandom % 4 == 0) ? NRATE'($urandom) : '1;
                sgi_allow = 1'($urandom);
            end
            r0 = ($urandom % 8 == 0) ? 0 : int'($urandom % 256);
            rd = ($urandom % 6 == 0) ? int'($urandom % 20) : int'($urandom % 3);
            rs = ($urandom % 5 == 0) ? int'($urandom % 100) : 45 + int'($urandom % 4);
            if ($urandom % 10 == 0)
                send("R2", 0, 0, 0, 0, 0, 0, rs);
            else
                send("R3 R4 R6 R7 R8", r0, int'($urandom % 16), int'($urandom % 8),
                     int'($urandom % 4), int'($urandom % 4), rd, rs);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule